// File: doc/BRIEF.md
# Interrupt Status Mask Coalescer

This block collects single-cycle event pulses from many interrupt sources into a 32-bit sticky status word. It ANDs that word with a 32-bit enable word and drives one level-sensitive interrupt line toward the host. The line is not raised the moment an enabled bit becomes pending. Instead, a coalescing timer counts a programmable number of 32-microsecond ticks, so that several events can be collected and reported by a single interrupt.

The host programs the block through a simple write port and a read port, each with a 2-bit register select. It acknowledges events by writing ones to the status word. A high-priority receive event skips the coalescing wait. A timeout of zero turns coalescing off. The 32-microsecond tick is supplied from outside by a prescaler as a one-cycle pulse.

Top module: `irq_coalescer`

## Requirements
- R1: A pulse on `evt_i[k]` sets status bit k on the next clock edge. A write with select 0 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. Status is read back with read select 0.
- R2: The enable word is written and read with select 1. Only status bits whose enable bit is 1 can raise `irq_o`. A pending bit that is not enabled leaves the line low.
- R3: When an enabled status bit becomes pending while the line is low, the timer loads the timeout value. On the clock edge that follows the tick that brings the count to zero, `irq_o` goes high.
- R4: The timeout register is 8 bits wide. It is written with select 2 (data bits 7:0) and read with select 2. It resets to 0x40. Status and enable reset to 0. Read select 3 returns status AND enable.
- R5: With a timeout of 0, `irq_o` rises on the clock edge after an enabled status bit is first seen pending. That is two edges after the event pulse.
- R6: Once high, `irq_o` stays high while any enabled status bit remains set. It falls on the edge after the enabled pending set becomes empty, whether the bits were cleared or their enables were removed.
- R7: A pulse on `hipri_i` sets status bit 31. If enable bit 31 is 1, it raises `irq_o` on the same edge, without waiting for the timer.
- R8: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: If the enabled pending set empties before the timer expires, the count is abandoned. The next pending event starts a full timeout again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | One-cycle event pulses, one per status bit |
| hipri_i | input | 1 | High-priority receive event pulse |
| tick_i | input | 1 | One-cycle pulse every 32 microseconds |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 status clear, 1 enable, 2 timeout |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select: 0 status, 1 enable, 2 timeout, 3 masked status |
| rd_data_o | output | 32 | Read data (combinational from registers) |
| irq_o | output | 1 | Host interrupt line |

## Verification
An event pulse shows up in the status readback one edge later. The interrupt line follows one edge after that with a zero timeout, or one edge after the final counted tick otherwise. A high-priority pulse raises the line on the very next edge. Clears and enable changes lower the line one edge after the register update. The bench drives stimulus on falling edges and keeps a behavioural model that advances on each rising edge. It compares the line and the read data a quarter period after every rising edge. The directed checks sample at the falling edge that follows the edge on which each result is due.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    parameter int unsigned STAT_W    = 32;
    parameter int unsigned TMO_W     = 8;
    parameter int unsigned HIPRI_BIT = 31;
    parameter logic [TMO_W-1:0] TMO_RESET = 8'h40;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_TMO    = 2'd2,
        SEL_MASKED = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             irq;
        logic             busy;
        logic [TMO_W-1:0] cnt;
    } line_st_t;

    typedef struct packed {
        stat_t            enable;
        logic [TMO_W-1:0] tmo;
    } cfg_st_t;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_coal_pkg::*;
#(
    parameter int unsigned W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] bits_d, bits_q;

    for (genvar k = 0; k < W; k++) begin : g_bit
        always_comb begin
            if (set_i[k])
                bits_d[k] = 1'b1;
            else if (clr_i[k])
                bits_d[k] = 1'b0;
            else
                bits_d[k] = bits_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign status_o = bits_q;

    // R1 / R8: a set request always lands, even against a clear
    p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R1: cleared bits without a competing set read as zero
    p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_line_timer.sv
module irq_line_timer
    import irq_coal_pkg::*;
#(
    parameter int unsigned TW = TMO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending_i,
    input  logic          bypass_i,
    input  logic          tick_i,
    input  logic [TW-1:0] timeout_i,
    output logic          irq_o
);
    localparam logic [TW-1:0] ONE = TW'(1);

    typedef struct packed {
        logic          irq;
        logic          busy;
        logic [TW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bypass_i) begin
            st_d.irq  = 1'b1;
            st_d.busy = 1'b0;
        end else if (st_q.irq) begin
            st_d.irq  = pending_i;
            st_d.busy = 1'b0;
        end else if (!pending_i) begin
            st_d.busy = 1'b0;
        end else if (timeout_i == '0) begin
            st_d.irq  = 1'b1;
            st_d.busy = 1'b0;
        end else if (!st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = timeout_i;
        end else if (tick_i) begin
            if (st_q.cnt == ONE) begin
                st_d.irq  = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R7: bypass raises the line on the next edge
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> irq_o);

    // R6: line holds while anything enabled is pending
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && pending_i) |=> irq_o);

    // R6: line falls once nothing enabled is pending
    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !pending_i && !bypass_i) |=> !irq_o);

    // R5: zero timeout delivers immediately
    p_zero_tmo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && pending_i && timeout_i == '0) |=> irq_o);

    // R9: no pending work means no rise without bypass
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !pending_i && !bypass_i) |=> !irq_o);
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import irq_coal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] evt_i,
    input  logic        hipri_i,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_sel_i,
    input  logic [31:0] wr_data_i,
    input  logic [1:0]  rd_sel_i,
    output logic [31:0] rd_data_o,
    output logic        irq_o
);
    localparam stat_t HIPRI_MASK = stat_t'(1) << HIPRI_BIT;

    cfg_st_t cfg_d, cfg_q;
    stat_t   status, set_req, clr_req, masked;
    logic    bypass;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && wr_sel_i == SEL_ENABLE) cfg_d.enable = wr_data_i;
        if (wr_en_i && wr_sel_i == SEL_TMO)    cfg_d.tmo    = wr_data_i[TMO_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.enable <= '0;
            cfg_q.tmo    <= TMO_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign set_req = evt_i | (hipri_i ? HIPRI_MASK : '0);
    assign clr_req = (wr_en_i && wr_sel_i == SEL_STATUS) ? wr_data_i : '0;

    irq_status_reg #(.W(STAT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_req),
        .clr_i    (clr_req),
        .status_o (status)
    );

    assign masked = status & cfg_q.enable;
    assign bypass = hipri_i & cfg_q.enable[HIPRI_BIT];

    irq_line_timer #(.TW(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (masked != '0),
        .bypass_i  (bypass),
        .tick_i    (tick_i),
        .timeout_i (cfg_q.tmo),
        .irq_o     (irq_o)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel_i))
            SEL_STATUS: rd_data_o = status;
            SEL_ENABLE: rd_data_o = cfg_q.enable;
            SEL_TMO:    rd_data_o = 32'(cfg_q.tmo);
            default:    rd_data_o = masked;
        endcase
    end

    // R2: the line never rises from bits that are not enabled
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && masked == '0 && !bypass) |=> !irq_o);

    // R4: timeout register only moves on its own write
    p_tmo_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == SEL_TMO) |=> $stable(cfg_q.tmo));
endmodule

// File: tb/sim_irq_coalescer.sv
module sim_irq_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        hipri_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [1:0]  rd_sel_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .hipri_i(hipri_i),
        .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    // tick every 8 cycles
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick_i = (div == 7);
            div = (div + 1) % 8;
        end
    end

    // behavioural reference
    logic [31:0] m_stat, m_en;
    logic [7:0]  m_tmo;
    bit          m_line, m_wait;
    int          m_rem;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_tmo = 8'h40;
            m_line = 0; m_wait = 0; m_rem = 0;
        end else begin
            bit pend;
            bit nl;
            logic [31:0] clr;
            pend = (m_stat & m_en) != 0;
            nl = m_line;
            if (hipri_i && m_en[31]) begin
                nl = 1; m_wait = 0;
            end else if (m_line) begin
                nl = pend; m_wait = 0;
            end else if (!pend) begin
                m_wait = 0;
            end else if (m_tmo == 0) begin
                nl = 1;
            end else if (!m_wait) begin
                m_wait = 1; m_rem = int'(m_tmo);
            end else if (tick_i) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin nl = 1; m_wait = 0; end
            end
            m_line = nl;
            clr = (wr_en_i && wr_sel_i == 2'd0) ? wr_data_i : 32'h0;
            m_stat = (m_stat & ~clr) | evt_i | (hipri_i ? 32'h8000_0000 : 32'h0);
            if (wr_en_i && wr_sel_i == 2'd1) m_en = wr_data_i;
            if (wr_en_i && wr_sel_i == 2'd2) m_tmo = wr_data_i[7:0];
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return m_stat;
            2'd1: return m_en;
            2'd2: return {24'h0, m_tmo};
            default: return m_stat & m_en;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check("R3 R6 line vs model", {31'h0, irq_o}, {31'h0, m_line});
            check("R1 R4 readback vs model", rd_data_o, m_read(rd_sel_i));
        end
    end

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        rd_sel_i = s; #1; v = rd_data_o;
    endtask
    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 0; wr_data_i = 0;
    endtask
    task automatic ev(input logic [31:0] m);
        evt_i = m; @(negedge clk); evt_i = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        // R4 reset values
        rd(2'd0, v); check("R4 status reset", v, 32'h0);
        rd(2'd1, v); check("R4 enable reset", v, 32'h0);
        rd(2'd2, v); check("R4 timeout reset", v, 32'h40);
        check("R4 irq reset", {31'h0, irq_o}, 32'h0);
        rd_sel_i = 0;

        // R3 coalesced delivery
        wr(2'd1, 32'h1);
        wr(2'd2, 32'h3);
        ev(32'h1);
        rd(2'd0, v); check("R1 event sets bit0", v, 32'h1);
        check("R3 not yet delivered", {31'h0, irq_o}, 32'h0);
        idle(2);
        check("R3 still waiting", {31'h0, irq_o}, 32'h0);
        idle(40);
        check("R3 delivered after timeout", {31'h0, irq_o}, 32'h1);

        // R6 hold and drop
        wr(2'd0, 32'h20);
        check("R6 unrelated clear keeps line", {31'h0, irq_o}, 32'h1);
        wr(2'd0, 32'h1);
        idle(1);
        check("R6 line drops after clear", {31'h0, irq_o}, 32'h0);

        // R2 masked bit
        wr(2'd2, 32'h0);
        ev(32'h200);
        rd(2'd0, v); check("R2 masked bit visible", v, 32'h200);
        rd(2'd3, v); check("R4 masked read", v, 32'h0);
        rd_sel_i = 0;
        idle(5);
        check("R2 masked bit no irq", {31'h0, irq_o}, 32'h0);
        wr(2'd0, 32'h200);

        // R5 zero timeout
        ev(32'h1);
        check("R5 one edge after event", {31'h0, irq_o}, 32'h0);
        idle(1);
        check("R5 immediate delivery", {31'h0, irq_o}, 32'h1);
        wr(2'd0, 32'h1);
        idle(1);

        // R7 high priority bypass
        wr(2'd2, 32'h40);
        wr(2'd1, 32'h8000_0001);
        hipri_i = 1; @(negedge clk); hipri_i = 0;
        check("R7 bypass raises line", {31'h0, irq_o}, 32'h1);
        rd(2'd0, v); check("R7 sets bit31", v, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000);
        idle(1);
        check("R7 line drops after ack", {31'h0, irq_o}, 32'h0);

        // R8 set beats clear, R1 zero write ignored
        evt_i = 32'h8;
        wr(2'd0, 32'h8);
        evt_i = 0;
        rd(2'd0, v); check("R8 set wins over clear", v, 32'h8);
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R1 zero write no effect", v, 32'h8);
        wr(2'd0, 32'h8);
        rd(2'd0, v); check("R1 clear by one", v, 32'h0);

        // R9 cancel and restart
        wr(2'd2, 32'h4);
        ev(32'h1);
        idle(10);
        wr(2'd0, 32'h1);
        idle(60);
        check("R9 cancelled no irq", {31'h0, irq_o}, 32'h0);
        ev(32'h1);
        idle(20);
        check("R9 restart full timeout", {31'h0, irq_o}, 32'h0);
        idle(30);
        check("R9 delivered after restart", {31'h0, irq_o}, 32'h1);

        // R6 enable removal drops line
        wr(2'd1, 32'h0);
        idle(1);
        check("R6 enable removal drops line", {31'h0, irq_o}, 32'h0);
        rd(2'd0, v); check("R6 status kept", v, 32'h1);
        wr(2'd0, 32'h1);
        idle(4);
        finish_run();
    end
endmodule